// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block is an 8-bit general-purpose I/O port for a processor register bus. Software sets each pin's direction, writes an output data latch, and reads either the latch or the live pin levels. The pad ring receives an output enable, an output value and a pull-up enable for every pin. The pad ring returns the raw pin level, which passes through a two-flop synchronizer before software can read it.

Each pin's direction bit controls whether its driver is on. A direction bit of 1 turns the driver off and makes the pin an input. A direction bit of 0 turns the driver on, and the pin is then driven from the latch. A write to the pin address or to the latch address updates the latch, whatever the pin direction. One pin can only drive low (open-drain). Pull-ups are controlled by a single active-low disable bit and apply to every input pin. A configuration code selects which pins are analog, and an analog pin always reads 0 at the pin address. There is no sequencing state machine: all behaviour is register state plus combinational decode.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 1, the latch is 0x00, the config register reads 0x80 (pull-ups disabled, code 0), every output enable is 0, and a read at the pin address returns 0x00 whatever the pins carry.
- R2: Address 2 holds the direction register, written on a clock edge with bus_we high. For every push-pull pin, pin_oe is the inverse of its direction bit from the cycle after the write.
- R3: A write to address 0 (pin address) or address 1 (latch address) updates the latch. A read at address 1 returns the latch, and pin_out of every push-pull pin equals its latch bit.
- R4: A read at address 0 returns each digital pin's level as it was two rising edges earlier (two-flop synchronizer).
- R5: A latch write to a pin whose direction bit is 1 changes the latch but leaves that pin's pin_oe at 0.
- R6: pull_en of a pin is 1 exactly when its direction bit is 1 and config bit 7 (active-low pull-up disable) is 0. A pin never has pull_en and pin_oe both high.
- R7: Pin 4 is open-drain. Its pin_out is always 0, and its pin_oe is 1 only when its direction bit is 0 and its latch bit is 0.
- R8: Config bits 3:0 hold the analog code. Codes 6 and 7 make every pin digital. Codes 8 to 15 make pins 0 to 3 analog and pins 4 to 7 digital. Codes 0 to 5 make every pin analog. An analog pin reads 0 at address 0.
- R9: Address 3 holds the config register. It reads back as bit 7 = pull-up disable, bits 6:4 = 0, and bits 3:0 = the code. A read at address 2 returns the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register address (0 pins, 1 latch, 2 direction, 3 config) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_oe | output | 8 | Per-pin driver enable |
| pin_out | output | 8 | Per-pin drive value |
| pull_en | output | 8 | Per-pin weak pull-up enable |

## Verification
On every cycle, the assertions check the following:
- pull-up and driver enables are mutually exclusive on each pin;
- the open-drain pin never drives high;
- a latch write with a 1 on the open-drain pin floats that pin;
- direction and latch writes show up on the pad controls one cycle later;
- all-analog codes zero the pin read;
- digital pin reads follow the pins with two cycles of delay.

Only the bench scenarios can show some behaviours:
- the reset values;
- the half-analog split;
- latch writes to input pins leaving the drivers off;
- readback of each register;
- the exact cycle in which a pin change becomes visible;
- the effect of a reset applied mid-run.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        ADDR_PINS  = 2'd0,
        ADDR_LATCH = 2'd1,
        ADDR_DIR   = 2'd2,
        ADDR_CFG   = 2'd3
    } gpio_addr_e;

    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_ALL_DIG_A = 4'd6;
    localparam logic [CODE_W-1:0] CODE_ALL_DIG_B = 4'd7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  gpio_addr_e        addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      lat_q,
    output logic              pu_dis_q,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '1;
            lat_q    <= '0;
            pu_dis_q <= 1'b1;
            code_q   <= '0;
        end else if (we) begin
            unique case (addr)
                ADDR_PINS, ADDR_LATCH: lat_q <= wdata;
                ADDR_DIR:              dir_q <= wdata;
                ADDR_CFG: begin
                    pu_dis_q <= wdata[W-1];
                    code_q   <= wdata[CODE_W-1:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int W      = 8,
    parameter int OD_PIN = 4
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lat,
    input  logic         pu_dis,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == OD_PIN) begin : g_od
            // drives only low; a latch 1 floats the pin
            assign oe[i]  = ~dir[i] & ~lat[i];
            assign out[i] = 1'b0;
        end else begin : g_pp
            assign oe[i]  = ~dir[i];
            assign out[i] = lat[i];
        end
        assign pu[i] = dir[i] & ~pu_dis;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W      = 8,
    parameter int OD_PIN = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pull_en
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] LOW_HALF = {{(W-HALF){1'b0}}, {HALF{1'b1}}};

    gpio_addr_e        addr_e;
    logic [W-1:0]      dir_q;
    logic [W-1:0]      lat_q;
    logic              pu_dis_q;
    logic [CODE_W-1:0] cfg_code;
    logic [W-1:0]      pins_sync;
    logic [W-1:0]      analog_mask;
    logic [W-1:0]      cfg_view;

    assign addr_e = gpio_addr_e'(bus_addr);

    gpio_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (addr_e),
        .wdata    (bus_wdata),
        .dir_q    (dir_q),
        .lat_q    (lat_q),
        .pu_dis_q (pu_dis_q),
        .code_q   (cfg_code)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_sync)
    );

    gpio_pad_ctl #(.W(W), .OD_PIN(OD_PIN)) u_pad (
        .dir    (dir_q),
        .lat    (lat_q),
        .pu_dis (pu_dis_q),
        .oe     (pin_oe),
        .out    (pin_out),
        .pu     (pull_en)
    );

    always_comb begin
        if (cfg_code == CODE_ALL_DIG_A || cfg_code == CODE_ALL_DIG_B)
            analog_mask = '0;
        else if (cfg_code[CODE_W-1])
            analog_mask = LOW_HALF;
        else
            analog_mask = '1;
    end

    assign cfg_view = {pu_dis_q, {(W-1-CODE_W){1'b0}}, cfg_code};

    always_comb begin
        unique case (addr_e)
            ADDR_PINS:  bus_rdata = pins_sync & ~analog_mask;
            ADDR_LATCH: bus_rdata = lat_q;
            ADDR_DIR:   bus_rdata = dir_q;
            ADDR_CFG:   bus_rdata = cfg_view;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W      = 8,
    parameter int OD_PIN = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_we,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pull_en,
    input logic [3:0]   cfg_code
);
    localparam logic [W-1:0] OD_M = W'(1) << OD_PIN;

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R6
    pu_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pull_en & pin_oe) == 0);

    // R7
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[OD_PIN] |-> !pin_out[OD_PIN]);

    // R7
    od_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1 && bus_wdata[OD_PIN]) |=> !pin_oe[OD_PIN]);

    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2) |=> ((pin_oe | OD_M) == (~$past(bus_wdata) | OD_M)));

    // R3
    latch_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 2'd0 || bus_addr == 2'd1))
            |=> ((pin_out & ~OD_M) == ($past(bus_wdata) & ~OD_M)));

    // R8
    analog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3 && bus_wdata[3:0] < 4'd6)
            |=> (bus_addr != 2'd0 || bus_rdata == '0));

    // R4
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && bus_addr == 2'd0 && (cfg_code == 4'd6 || cfg_code == 4'd7))
            |-> bus_rdata == $past(pin_in, 2));
endmodule

bind gpio_port gpio_port_chk #(.W(W), .OD_PIN(OD_PIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pull_en   (pull_en),
    .cfg_code  (cfg_code)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic [7:0] pull_en;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    gpio_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .pull_en   (pull_en)
    );

    typedef struct packed {
        logic       we;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [7:0] pins;
        logic [1:0] chk;
        logic [7:0] rd;
        logic [7:0] oe;
        logic [7:0] pu;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd3, 8'h06, 8'h00, 2'd3, 8'h06, 8'h00, 8'hFF}, // R9 config readback, pull-ups on
        '{1'b1, 2'd2, 8'h00, 8'h00, 2'd1, 8'h00, 8'hFF, 8'h00}, // R2 all outputs
        '{1'b1, 2'd0, 8'hA5, 8'h00, 2'd1, 8'hA5, 8'hFF, 8'h00}, // R3 latch via pin address
        '{1'b1, 2'd1, 8'h5A, 8'h00, 2'd1, 8'h5A, 8'hEF, 8'h00}, // R7 open-drain floats on 1
        '{1'b1, 2'd2, 8'hF0, 8'h3C, 2'd0, 8'h3C, 8'h0F, 8'hF0}, // R4 digital pin read
        '{1'b1, 2'd3, 8'h0A, 8'hFF, 2'd0, 8'hF0, 8'h0F, 8'hF0}, // R8 low half analog
        '{1'b1, 2'd3, 8'h02, 8'hFF, 2'd0, 8'h00, 8'h0F, 8'hF0}, // R8 all analog
        '{1'b1, 2'd3, 8'h07, 8'hC3, 2'd0, 8'hC3, 8'h0F, 8'hF0}, // R8 code 7 digital
        '{1'b1, 2'd0, 8'hFF, 8'h00, 2'd1, 8'hFF, 8'h0F, 8'hF0}  // R5 write to inputs
    };
    localparam string TAG [NV] = '{"R9", "R2", "R3", "R7", "R4", "R8", "R8", "R8", "R5"};

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, "rdata", bus_rdata, exp);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        pin_in = 8'hFF;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "oe", pin_oe, 8'h00);
        check("R1", "pull_en", pull_en, 8'h00);
        rd_chk("R1", 2'd2, 8'hFF);
        rd_chk("R1", 2'd1, 8'h00);
        rd_chk("R1", 2'd3, 8'h80);
        rd_chk("R1", 2'd0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pin_in = TBL[i].pins;
            bus_we = TBL[i].we; bus_addr = TBL[i].addr; bus_wdata = TBL[i].wdata;
            @(negedge clk);
            bus_we = 1'b0;
            @(negedge clk);
            @(negedge clk);
            rd_chk(TAG[i], TBL[i].chk, TBL[i].rd);
            check(TAG[i], "oe", pin_oe, TBL[i].oe);
            check(TAG[i], "pull_en", pull_en, TBL[i].pu);
        end

        // R3 / R7 drive values: latch FF, dir F0
        check("R3", "pin_out", pin_out & 8'hEF, 8'hEF);
        check("R7", "od_out", {7'd0, pin_out[4]}, 8'h00);
        rd_chk("R9", 2'd2, 8'hF0);

        // R4 exact latency: pins 00 -> 81 while all digital
        @(negedge clk);
        pin_in = 8'h81;
        bus_addr = 2'd0;
        @(negedge clk);
        #1 check("R4", "after one edge", bus_rdata, 8'h00);
        @(negedge clk);
        #1 check("R4", "after two edges", bus_rdata, 8'h81);

        // R7 open-drain driven low when direction 0 and latch 0
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        #1 check("R7", "od_oe", {7'd0, pin_oe[4]}, 8'h01);
        check("R7", "od_out", {7'd0, pin_out[4]}, 8'h00);

        // R6 pull-up disable bit set
        wr(2'd2, 8'h3C);
        wr(2'd3, 8'h87);
        #1 check("R6", "pull_en disabled", pull_en, 8'h00);
        wr(2'd3, 8'h07);
        #1 check("R6", "pull_en enabled", pull_en, 8'h3C);
        rd_chk("R9", 2'd3, 8'h07);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        rd_chk("R1", 2'd2, 8'hFF);
        check("R1", "oe after reset", pin_oe, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule